// File: doc/BRIEF.md
# DMA Host Register Interface

This block is the register file that a host processor uses to program a four-channel DMA engine over an 8-bit bus. The host picks a register with a bank select and a 4-bit offset, and strobes a write or a read. Each channel keeps a base address and a base count, which stay fixed until software writes them. It also keeps a current address and a current count, which the transfer engine advances. Channel state also includes a mode byte, a mask bit, a software request bit and an 8-bit page value. The page value supplies the upper address bits, which gives a 24-bit address.

Each 16-bit address or count passes through one 8-bit port as two accesses, and an internal byte pointer chooses which byte each access reaches. Writes load the base value and the current value together. Reads return the current value, so software can follow a transfer while it runs.

The transfer engine sits outside this block. It reads the mask, the mode, the command byte and the list of pending requests. It pulses a step input for the channel it served, and it sees the full address and the remaining count of that channel.

Top module: `dma_regif`

## Requirements
- R1: After reset all four mask bits are 1 and the byte pointer selects the low byte. The command byte, the request bits, the terminal-count bits, the modes, the pages and every address and count are 0.
- R2: In the channel bank (bank_sel=0), an even offset selects channel port_off[3:2]. port_off[1]=0 selects the address and port_off[1]=1 selects the count. Writes to odd offsets change nothing and leave the byte pointer alone, and reads from odd offsets return 0.
- R3: Every read or write of a channel-bank even offset reaches the low byte when the pointer is 0 and the high byte when it is 1, and then toggles the pointer. A write to control offset 0x8 (bank_sel=1) sets the pointer back to low.
- R4: A write loads the addressed byte into both the base value and the current value. A read returns the current address or the current count.
- R5: A step of channel step_ch decrements its count modulo 2^16. It increments its address modulo 2^16, or decrements it when mode bit 3 (write-data bit 5) is 1. Carries never reach the page.
- R6: A step taken while the count is 0 sets that channel's terminal-count bit. When mode bit 2 (write-data bit 4) is 1, that step reloads the current address and count from the base values instead of stepping them. Reading control offset 0x0 returns {request bits[3:0], terminal-count bits[3:0]} and clears the terminal-count bits.
- R7: A write to control offset 0x4 sets the mask of channel wr_data[1:0] to wr_data[2]. Masks change only on host writes.
- R8: A write to control offset 0xE loads all masks from wr_data[3:0]. A write to control offset 0xC clears all masks.
- R9: A write to control offset 0xA sets all masks and returns the pointer to low. It also clears the command byte, the request bits and the terminal-count bits. Addresses and counts are kept.
- R10: In the page bank (bank_sel=2), offsets 0 to 3 read and write the page of channel port_off[1:0]. eng_addr is {page, current address} of channel step_ch.
- R11: pend_out[i] is (dreq[i] or request bit i) and not mask i. All of pend_out is 0 while command bit 2 is 1.
- R12: A write to control offset 0x6 stores wr_data[7:2] as the mode of channel wr_data[1:0], which appears at mode_out[6i+5:6i]. A write to control offset 0x2 sets the request bit of channel wr_data[1:0] to wr_data[2]. A write to control offset 0x0 loads the command byte.
- R13: A host write to a channel's address or count takes effect in the same cycle as a step of that channel, and the step is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bank_sel | input | 2 | 0 channel, 1 control, 2 page, 3 unused |
| port_off | input | 4 | Register offset within the bank |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (ignored while wr_en is high) |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid while rd_en is high |
| dreq | input | 4 | Hardware request lines |
| step_en | input | 1 | Engine completed one transfer |
| step_ch | input | 2 | Channel served by the engine |
| cmd_out | output | 8 | Command byte |
| mask_out | output | 4 | Mask bits |
| mode_out | output | 24 | Six mode bits per channel |
| pend_out | output | 4 | Unmasked pending requests |
| eng_addr | output | 24 | Page and current address of step_ch |
| eng_count | output | 16 | Current count of step_ch |

## Verification
The byte path is driven in three orders: two clean accesses, a low write followed by a pointer clear and a fresh pair, and odd-offset accesses placed between the two bytes. These orders separate a pointer that toggles correctly from one that ignores the clear or that toggles on odd offsets. Stepping is tried in increment mode, in decrement-with-reload mode and across the 0xFFFF address wrap, which separates a one-shot terminal count from a reload and shows that the page holds still. Masks are set through all four mask ports, with pending requests observed under each. A host write that lands on the same cycle as a step shows which of the two wins.

// File: rtl/dma_regif_pkg.sv
package dma_regif_pkg;

  typedef enum logic [1:0] {
    BANK_CHAN = 2'd0,
    BANK_CTRL = 2'd1,
    BANK_PAGE = 2'd2,
    BANK_NONE = 2'd3
  } bank_e;

  localparam logic [3:0] CTL_CMD_STAT = 4'h0;
  localparam logic [3:0] CTL_REQ      = 4'h2;
  localparam logic [3:0] CTL_SMASK    = 4'h4;
  localparam logic [3:0] CTL_MODE     = 4'h6;
  localparam logic [3:0] CTL_CLRPTR   = 4'h8;
  localparam logic [3:0] CTL_MCLR     = 4'hA;
  localparam logic [3:0] CTL_CLRMASK  = 4'hC;
  localparam logic [3:0] CTL_ALLMASK  = 4'hE;

  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;

  function automatic logic [WORD_W-1:0] f_step_addr(input logic [WORD_W-1:0] a,
                                                    input logic dec);
    return dec ? (a - WORD_W'(1)) : (a + WORD_W'(1));
  endfunction

  function automatic logic [WORD_W-1:0] f_step_cnt(input logic [WORD_W-1:0] c);
    return c - WORD_W'(1);
  endfunction

  function automatic logic [BYTE_W-1:0] f_pick_byte(input logic [WORD_W-1:0] w,
                                                    input logic hi);
    return hi ? w[WORD_W-1:BYTE_W] : w[BYTE_W-1:0];
  endfunction

endpackage

// File: rtl/dma_regif_chan.sv
module dma_regif_chan
  import dma_regif_pkg::*;
#(
  parameter int WW = WORD_W,
  parameter int DW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_lo_a,
  input  logic          wr_hi_a,
  input  logic          wr_lo_c,
  input  logic          wr_hi_c,
  input  logic [DW-1:0] wdata,
  input  logic          step,
  input  logic          dec,
  input  logic          autoinit,
  output logic [WW-1:0] cur_addr,
  output logic [WW-1:0] cur_cnt,
  output logic          tc_evt
);
  logic [WW-1:0] base_a, base_c;
  logic          host_wr, step_go;

  assign host_wr = wr_lo_a | wr_hi_a | wr_lo_c | wr_hi_c;
  assign step_go = step & ~host_wr;
  assign tc_evt  = step_go & (cur_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_a   <= '0;
      base_c   <= '0;
      cur_addr <= '0;
      cur_cnt  <= '0;
    end else if (host_wr) begin
      if (wr_lo_a) begin
        base_a[DW-1:0]   <= wdata;
        cur_addr[DW-1:0] <= wdata;
      end
      if (wr_hi_a) begin
        base_a[WW-1:DW]   <= wdata;
        cur_addr[WW-1:DW] <= wdata;
      end
      if (wr_lo_c) begin
        base_c[DW-1:0]  <= wdata;
        cur_cnt[DW-1:0] <= wdata;
      end
      if (wr_hi_c) begin
        base_c[WW-1:DW]  <= wdata;
        cur_cnt[WW-1:DW] <= wdata;
      end
    end else if (step_go) begin
      if (tc_evt && autoinit) begin
        cur_addr <= base_a;
        cur_cnt  <= base_c;
      end else begin
        cur_addr <= f_step_addr(cur_addr, dec);
        cur_cnt  <= f_step_cnt(cur_cnt);
      end
    end
  end
endmodule

// File: rtl/dma_regif_ctrl.sv
module dma_regif_ctrl
  import dma_regif_pkg::*;
#(
  parameter int CH_N   = 4,
  parameter int DW     = BYTE_W,
  parameter int MODE_W = DW - 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_cmd,
  input  logic                   wr_req,
  input  logic                   wr_smask,
  input  logic                   wr_mode,
  input  logic                   wr_clrptr,
  input  logic                   wr_mclr,
  input  logic                   wr_clrmask,
  input  logic                   wr_allmask,
  input  logic                   rd_status,
  input  logic                   ptr_toggle,
  input  logic [DW-1:0]          wdata,
  input  logic [CH_N-1:0]        tc_evt,
  output logic [DW-1:0]          cmd_q,
  output logic [CH_N-1:0]        mask_q,
  output logic [CH_N-1:0]        req_q,
  output logic [CH_N-1:0]        tc_q,
  output logic [CH_N*MODE_W-1:0] mode_flat,
  output logic                   ptr_q
);
  localparam int CH_W = $clog2(CH_N);

  logic [CH_W-1:0] wsel;
  assign wsel = wdata[CH_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      mask_q <= '1;
      req_q  <= '0;
      tc_q   <= '0;
      ptr_q  <= 1'b0;
    end else if (wr_mclr) begin
      cmd_q  <= '0;
      mask_q <= '1;
      req_q  <= '0;
      tc_q   <= '0;
      ptr_q  <= 1'b0;
    end else begin
      if (wr_cmd)          cmd_q <= wdata;
      if (wr_req)          req_q[wsel] <= wdata[CH_W];
      if (wr_smask)        mask_q[wsel] <= wdata[CH_W];
      else if (wr_allmask) mask_q <= wdata[CH_N-1:0];
      else if (wr_clrmask) mask_q <= '0;
      tc_q <= (rd_status ? '0 : tc_q) | tc_evt;
      if (wr_clrptr)       ptr_q <= 1'b0;
      else if (ptr_toggle) ptr_q <= ~ptr_q;
    end
  end

  for (genvar i = 0; i < CH_N; i++) begin : g_mode
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mode_flat[i*MODE_W +: MODE_W] <= '0;
      else if (wr_mode && wsel == CH_W'(i))
        mode_flat[i*MODE_W +: MODE_W] <= wdata[DW-1:DW-MODE_W];
    end
  end
endmodule

// File: rtl/dma_regif_page.sv
module dma_regif_page #(
  parameter int CH_N = 4,
  parameter int PW   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CH_N-1:0]      wr_sel,
  input  logic [PW-1:0]        wdata,
  output logic [CH_N*PW-1:0]   page_flat
);
  for (genvar i = 0; i < CH_N; i++) begin : g_pg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         page_flat[i*PW +: PW] <= '0;
      else if (wr_sel[i]) page_flat[i*PW +: PW] <= wdata;
    end
  end
endmodule

// File: rtl/dma_regif.sv
module dma_regif
  import dma_regif_pkg::*;
#(
  parameter int CH_N   = 4,
  parameter int DW     = BYTE_W,
  parameter int WW     = WORD_W,
  parameter int PW     = 8,
  parameter int MODE_W = DW - 2,
  localparam int CH_W  = $clog2(CH_N),
  localparam int AW    = PW + WW
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             bank_sel,
  input  logic [3:0]             port_off,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [DW-1:0]          wr_data,
  output logic [DW-1:0]          rd_data,
  input  logic [CH_N-1:0]        dreq,
  input  logic                   step_en,
  input  logic [CH_W-1:0]        step_ch,
  output logic [DW-1:0]          cmd_out,
  output logic [CH_N-1:0]        mask_out,
  output logic [CH_N*MODE_W-1:0] mode_out,
  output logic [CH_N-1:0]        pend_out,
  output logic [AW-1:0]          eng_addr,
  output logic [WW-1:0]          eng_count
);
  // decode events, visible to the checker
  logic            rd_go, acc_chan, ctl_wr, ptr_toggle, clr_ptr_ev, mclr_ev, rd_status;
  logic [CH_W-1:0] ch_sel;
  logic            is_cnt, ptr_q;
  logic [CH_N-1:0] tc_ev, req_q, tc_q, pg_wr;
  logic [DW-1:0]   status_q;
  logic [CH_N*PW-1:0] page_flat;
  logic [WW-1:0]   cur_a [CH_N];
  logic [WW-1:0]   cur_c [CH_N];

  assign rd_go      = rd_en & ~wr_en;
  assign acc_chan   = (bank_e'(bank_sel) == BANK_CHAN) & ~port_off[0];
  assign ch_sel     = port_off[3:2];
  assign is_cnt     = port_off[1];
  assign ctl_wr     = wr_en & (bank_e'(bank_sel) == BANK_CTRL);
  assign ptr_toggle = (wr_en | rd_go) & acc_chan;
  assign mclr_ev    = ctl_wr & (port_off == CTL_MCLR);
  assign clr_ptr_ev = ctl_wr & (port_off == CTL_CLRPTR);
  assign rd_status  = rd_go & (bank_e'(bank_sel) == BANK_CTRL) & (port_off == CTL_CMD_STAT);
  assign status_q   = {req_q, tc_q};

  for (genvar i = 0; i < CH_N; i++) begin : g_ch
    logic hit;
    assign hit   = wr_en & acc_chan & (ch_sel == CH_W'(i));
    assign pg_wr[i] = wr_en & (bank_e'(bank_sel) == BANK_PAGE) &
                      (port_off[3:CH_W] == '0) & (port_off[CH_W-1:0] == CH_W'(i));
    dma_regif_chan #(.WW(WW), .DW(DW)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_lo_a  (hit & ~is_cnt & ~ptr_q),
      .wr_hi_a  (hit & ~is_cnt &  ptr_q),
      .wr_lo_c  (hit &  is_cnt & ~ptr_q),
      .wr_hi_c  (hit &  is_cnt &  ptr_q),
      .wdata    (wr_data),
      .step     (step_en & (step_ch == CH_W'(i))),
      .dec      (mode_out[i*MODE_W + 3]),
      .autoinit (mode_out[i*MODE_W + 2]),
      .cur_addr (cur_a[i]),
      .cur_cnt  (cur_c[i]),
      .tc_evt   (tc_ev[i])
    );
  end

  dma_regif_ctrl #(.CH_N(CH_N), .DW(DW), .MODE_W(MODE_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_cmd     (ctl_wr & (port_off == CTL_CMD_STAT)),
    .wr_req     (ctl_wr & (port_off == CTL_REQ)),
    .wr_smask   (ctl_wr & (port_off == CTL_SMASK)),
    .wr_mode    (ctl_wr & (port_off == CTL_MODE)),
    .wr_clrptr  (clr_ptr_ev),
    .wr_mclr    (mclr_ev),
    .wr_clrmask (ctl_wr & (port_off == CTL_CLRMASK)),
    .wr_allmask (ctl_wr & (port_off == CTL_ALLMASK)),
    .rd_status  (rd_status),
    .ptr_toggle (ptr_toggle),
    .wdata      (wr_data),
    .tc_evt     (tc_ev),
    .cmd_q      (cmd_out),
    .mask_q     (mask_out),
    .req_q      (req_q),
    .tc_q       (tc_q),
    .mode_flat  (mode_out),
    .ptr_q      (ptr_q)
  );

  dma_regif_page #(.CH_N(CH_N), .PW(PW)) u_page (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_sel    (pg_wr),
    .wdata     (wr_data[PW-1:0]),
    .page_flat (page_flat)
  );

  always_comb begin
    rd_data = '0;
    if (rd_go) begin
      unique case (bank_e'(bank_sel))
        BANK_CHAN: if (!port_off[0])
                     rd_data = f_pick_byte(is_cnt ? cur_c[ch_sel] : cur_a[ch_sel], ptr_q);
        BANK_CTRL: if (port_off == CTL_CMD_STAT) rd_data = status_q;
        BANK_PAGE: if (port_off[3:CH_W] == '0)
                     rd_data = DW'(page_flat[port_off[CH_W-1:0]*PW +: PW]);
        default:   rd_data = '0;
      endcase
    end
  end

  assign pend_out  = (dreq | req_q) & ~mask_out & {CH_N{~cmd_out[2]}};
  assign eng_addr  = {page_flat[step_ch*PW +: PW], cur_a[step_ch]};
  assign eng_count = cur_c[step_ch];
endmodule

// File: rtl/dma_regif_chk.sv
module dma_regif_chk #(
  parameter int CH_N = 4,
  parameter int DW   = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic            ptr_toggle,
  input logic            clr_ptr_ev,
  input logic            mclr_ev,
  input logic            ptr_q,
  input logic [CH_N-1:0] tc_ev,
  input logic [CH_N-1:0] mask_out,
  input logic [DW-1:0]   status_q
);
  AST_PTR_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_toggle |=> ptr_q != $past(ptr_q)); // R3
  AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ptr_ev |=> !ptr_q); // R3
  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mask_out)); // R7
  AST_MCLR_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    mclr_ev |=> (&mask_out) && !ptr_q && (status_q == '0)); // R9
  AST_TC_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_ev != '0) |=> (status_q[CH_N-1:0] & $past(tc_ev)) == $past(tc_ev)); // R6
endmodule

bind dma_regif dma_regif_chk #(.CH_N(CH_N), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .ptr_toggle (ptr_toggle),
  .clr_ptr_ev (clr_ptr_ev),
  .mclr_ev    (mclr_ev),
  .ptr_q      (ptr_q),
  .tc_ev      (tc_ev),
  .mask_out   (mask_out),
  .status_q   (status_q)
);

// File: tb/dma_regif_tb_top.sv
`timescale 1ns/1ps
module dma_regif_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bank_sel = '0;
  logic [3:0]  port_off = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic [3:0]  dreq = '0;
  logic        step_en = 1'b0;
  logic [1:0]  step_ch = '0;
  logic [7:0]  cmd_out;
  logic [3:0]  mask_out, pend_out;
  logic [23:0] mode_out, eng_addr;
  logic [15:0] eng_count;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } exp_t;
  exp_t sb_q[$];
  exp_t cur_e;

  always #2.5 clk = ~clk;

  dma_regif dut_i (
    .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .port_off(port_off),
    .wr_en(wr_en), .rd_en(rd_en), .wr_data(wr_data), .rd_data(rd_data),
    .dreq(dreq), .step_en(step_en), .step_ch(step_ch), .cmd_out(cmd_out),
    .mask_out(mask_out), .mode_out(mode_out), .pend_out(pend_out),
    .eng_addr(eng_addr), .eng_count(eng_count)
  );

  // monitor: compares read data against the scoreboard
  always @(negedge clk) begin
    #1;
    if (rd_en) begin
      if (sb_q.size() == 0) begin
        n_bad++;
        $display("FAIL monitor: read with empty scoreboard act=%h exp=none", rd_data);
      end else begin
        cur_e = sb_q.pop_front();
        n_chk++;
        if (rd_data !== cur_e.exp) begin
          n_bad++;
          $display("FAIL %s: act=%h exp=%h", cur_e.tag, rd_data, cur_e.exp);
        end
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(logic [1:0] b, logic [3:0] o, logic [7:0] d);
    @(negedge clk);
    bank_sel = b; port_off = o; wr_data = d; wr_en = 1'b1; rd_en = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(logic [1:0] b, logic [3:0] o, logic [7:0] exp, string tag);
    exp_t e;
    @(negedge clk);
    bank_sel = b; port_off = o; rd_en = 1'b1; wr_en = 1'b0;
    e.exp = exp; e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic do_step(logic [1:0] ch);
    @(negedge clk);
    step_en = 1'b1; step_ch = ch;
    @(negedge clk);
    step_en = 1'b0;
  endtask

  task automatic clrptr();
    bus_wr(2'd1, 4'h8, 8'h00);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: act=running exp=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    dreq = 4'hF;
    @(negedge clk);
    #1;
    // R1 reset state
    chk("R1 mask", 32'(mask_out), 32'hF);
    chk("R1 cmd", 32'(cmd_out), 32'h0);
    chk("R1 mode", 32'(mode_out), 32'h0);
    chk("R11 masked pend", 32'(pend_out), 32'h0);
    bus_rd(2'd1, 4'h0, 8'h00, "R1 status");
    bus_rd(2'd0, 4'h0, 8'h00, "R1 addr lo");
    bus_rd(2'd0, 4'h0, 8'h00, "R1 addr hi");
    dreq = 4'h0;

    // R4 / R3 plain low-high pairs, ch1
    clrptr();
    bus_wr(2'd0, 4'h4, 8'h34); bus_wr(2'd0, 4'h4, 8'h12);
    bus_wr(2'd0, 4'h6, 8'h02); bus_wr(2'd0, 4'h6, 8'h00);
    bus_rd(2'd0, 4'h4, 8'h34, "R4 ch1 addr lo");
    bus_rd(2'd0, 4'h4, 8'h12, "R4 ch1 addr hi");
    bus_rd(2'd0, 4'h6, 8'h02, "R4 ch1 cnt lo");
    bus_rd(2'd0, 4'h6, 8'h00, "R4 ch1 cnt hi");

    // R3 clear in the middle of a pair, ch2
    bus_wr(2'd0, 4'h8, 8'hAA);
    clrptr();
    bus_wr(2'd0, 4'h8, 8'hBB); bus_wr(2'd0, 4'h8, 8'hCC);
    bus_rd(2'd0, 4'h8, 8'hBB, "R3 clear lo");
    bus_rd(2'd0, 4'h8, 8'hCC, "R3 clear hi");

    // R2 odd offsets ignored
    bus_wr(2'd0, 4'h5, 8'h77);
    bus_rd(2'd0, 4'h4, 8'h34, "R2 odd write no toggle lo");
    bus_rd(2'd0, 4'h5, 8'h00, "R2 odd read zero");
    bus_rd(2'd0, 4'h4, 8'h12, "R2 odd read no toggle hi");
    bus_rd(2'd0, 4'h4, 8'h34, "R2 pointer back lo");
    bus_rd(2'd0, 4'h4, 8'h12, "R2 pointer back hi");

    // R10 page, R5 increment stepping, R6 one-shot terminal count
    bus_wr(2'd2, 4'h1, 8'h5A);
    bus_rd(2'd2, 4'h1, 8'h5A, "R10 page readback");
    do_step(2'd1);
    #1;
    chk("R10 eng_addr", 32'(eng_addr), 32'h5A1235);
    chk("R5 count dec", 32'(eng_count), 32'h0001);
    bus_rd(2'd0, 4'h4, 8'h35, "R4 current lo");
    bus_rd(2'd0, 4'h4, 8'h12, "R4 current hi");
    do_step(2'd1);
    bus_rd(2'd1, 4'h0, 8'h00, "R6 no tc yet");
    do_step(2'd1);
    step_ch = 2'd1;
    #1;
    chk("R6 one-shot count", 32'(eng_count), 32'hFFFF);
    chk("R6 one-shot addr", 32'(eng_addr), 32'h5A1237);
    bus_rd(2'd1, 4'h0, 8'h02, "R6 tc bit ch1");
    bus_rd(2'd1, 4'h0, 8'h00, "R6 tc cleared by read");

    // R12 mode, R5 decrement, R6 autoinit reload on ch2
    bus_wr(2'd1, 4'h6, 8'h32);
    #1;
    chk("R12 mode ch2", 32'(mode_out[12 +: 6]), 32'h0C);
    clrptr();
    bus_wr(2'd0, 4'hA, 8'h01); bus_wr(2'd0, 4'hA, 8'h00);
    do_step(2'd2);
    #1;
    chk("R5 decrement addr", 32'(eng_addr), 32'h00CCBA);
    chk("R5 count zero", 32'(eng_count), 32'h0000);
    do_step(2'd2);
    #1;
    chk("R6 reload addr", 32'(eng_addr), 32'h00CCBB);
    chk("R6 reload count", 32'(eng_count), 32'h0001);
    bus_rd(2'd1, 4'h0, 8'h04, "R6 tc bit ch2");

    // R5 address wrap keeps page, ch3
    bus_wr(2'd0, 4'hC, 8'hFF); bus_wr(2'd0, 4'hC, 8'hFF);
    bus_wr(2'd0, 4'hE, 8'h05); bus_wr(2'd0, 4'hE, 8'h00);
    bus_wr(2'd2, 4'h3, 8'h01);
    do_step(2'd3);
    #1;
    chk("R5 wrap page fixed", 32'(eng_addr), 32'h010000);

    // R7 R8 R11 masks and pending
    dreq = 4'hF;
    bus_wr(2'd1, 4'h4, 8'h01);
    #1;
    chk("R7 single unmask ch1", 32'(mask_out), 32'hD);
    chk("R11 pend one", 32'(pend_out), 32'h2);
    bus_wr(2'd1, 4'hE, 8'h05);
    #1;
    chk("R8 write all", 32'(mask_out), 32'h5);
    chk("R11 pend all-mask", 32'(pend_out), 32'hA);
    bus_wr(2'd1, 4'hC, 8'h00);
    #1;
    chk("R8 clear all", 32'(mask_out), 32'h0);
    bus_wr(2'd1, 4'h0, 8'h04);
    #1;
    chk("R12 cmd", 32'(cmd_out), 32'h04);
    chk("R11 disable", 32'(pend_out), 32'h0);
    bus_wr(2'd1, 4'h0, 8'h00);
    bus_wr(2'd1, 4'h4, 8'h06);
    #1;
    chk("R7 single mask ch2", 32'(mask_out), 32'h4);
    dreq = 4'h0;
    bus_wr(2'd1, 4'h2, 8'h07);
    #1;
    chk("R12 sw request ch3", 32'(pend_out), 32'h8);
    bus_rd(2'd1, 4'h0, 8'h80, "R6 status request bits");

    // R9 master clear
    bus_wr(2'd0, 4'h0, 8'h99);
    bus_wr(2'd1, 4'h0, 8'h55);
    bus_wr(2'd1, 4'hA, 8'h00);
    #1;
    chk("R9 masks set", 32'(mask_out), 32'hF);
    chk("R9 cmd cleared", 32'(cmd_out), 32'h0);
    bus_wr(2'd1, 4'hC, 8'h00);
    #1;
    chk("R9 request cleared", 32'(pend_out), 32'h0);
    bus_rd(2'd1, 4'h0, 8'h00, "R9 status cleared");
    bus_wr(2'd0, 4'h0, 8'h11); bus_wr(2'd0, 4'h0, 8'h22);
    bus_rd(2'd0, 4'h0, 8'h11, "R9 pointer low");
    bus_rd(2'd0, 4'h0, 8'h22, "R9 pointer high");
    bus_rd(2'd0, 4'h4, 8'h37, "R9 addresses kept");
    bus_rd(2'd0, 4'h4, 8'h12, "R9 addresses kept hi");

    // R13 host write beats step on the same channel
    @(negedge clk);
    bank_sel = 2'd0; port_off = 4'h0; wr_data = 8'h40; wr_en = 1'b1;
    step_en = 1'b1; step_ch = 2'd0;
    @(negedge clk);
    wr_en = 1'b0; step_en = 1'b0;
    clrptr();
    bus_rd(2'd0, 4'h0, 8'h40, "R13 write wins lo");
    bus_rd(2'd0, 4'h0, 8'h22, "R13 write wins hi");
    bus_rd(2'd0, 4'h2, 8'h00, "R13 step dropped cnt lo");
    bus_rd(2'd0, 4'h2, 8'h00, "R13 step dropped cnt hi");

    repeat (3) @(negedge clk);
    if (sb_q.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard: act=%0d left exp=0", sb_q.size());
    end
    finish_run();
  end
endmodule